// File: doc/BRIEF.md
# In-order pipeline hazard stall controller

This block sequences abstract instruction tokens through a four-stage in-order pipeline: fetch, decode, issue and execute. Each token carries a tag, an optional destination register and up to three source registers, each with its own enable bit. The fetch stage is the acceptance of the token on the input port. Decode, issue and execute are one register each, so each stage holds at most one token.

A busy bit per register marks writes that are still in flight. A token in decode whose enabled sources hit a busy bit raises a single global stall. While the stall is up, fetch takes nothing, decode keeps its token and issue receives an empty slot. The token already in issue still moves on through execute. There is no forwarding, so a reader waits until its writer has left execute.

The block outputs, every cycle, the contents of each stage and the stall flag. It also keeps a count of retired tokens and a count of elapsed cycles, and their ratio gives the achieved instructions per clock. The token source must hold its offered token until `fetch_take` is high.

Top module: `hzd_stall_pipe`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `dec_valid`, `iss_valid`, `exe_valid`, `stall`, `retired` and `cycles` are all 0, and every register reads as not busy.
- R2: In a cycle where `in_valid` is 1 and `stall` is 0, `fetch_take` is 1 and the token appears in decode in the next cycle. In a cycle with no stall and `in_valid` 0, decode is empty in the next cycle.
- R3: Without a stall, a token in decode is in issue in the next cycle and in execute the cycle after. Execute holds a token for exactly one cycle. Independent back-to-back tokens leave execute on consecutive cycles.
- R4: `stall` is 1 exactly when decode holds a token and one of its enabled source slots names a busy register. Source slot g is bits [g*5 +: 5] of `in_src` and is enabled by bit g of `in_src_en`. A disabled slot is never checked, whatever register it names. A destination becomes busy at the edge where its token moves from decode to issue.
- R5: While `stall` is 1, `fetch_take` is 0, decode keeps the same token, and issue is empty in the next cycle. A token already in issue still advances into execute.
- R6: A busy bit is cleared at the edge that ends the writer's execute cycle. A blocked reader leaves decode in the first cycle its bit reads clear. For a writer (cycle 1), a reader of its destination (cycle 2) and a third token that also reads it, presented back to back, the three tokens are in execute in cycles 4, 7 and 8, with `stall` high for 2 cycles.
- R7: A token with `in_dst_en` 0 marks no register busy.
- R8: When two in-flight writers target the same register, the older one leaving execute does not clear the bit. It stays busy until the newer writer has executed. For writer, writer, reader on one register presented back to back, the reader is in execute in cycle 8.
- R9: `retired` increases by one after each cycle in which execute holds a token. `cycles` increases by one after every clock out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A token is offered |
| in_tag | input | TAGW | Token tag |
| in_dst_en | input | 1 | Token writes a destination |
| in_dst | input | 5 | Destination register |
| in_src_en | input | 3 | Per-slot source enables |
| in_src | input | 15 | Source registers, slot g at [g*5 +: 5] |
| fetch_take | output | 1 | Offered token accepted this cycle |
| stall | output | 1 | Global hazard stall |
| dec_valid | output | 1 | Decode occupied |
| dec_tag | output | TAGW | Decode token tag |
| iss_valid | output | 1 | Issue occupied |
| iss_tag | output | TAGW | Issue token tag |
| exe_valid | output | 1 | Execute occupied |
| exe_tag | output | TAGW | Execute token tag |
| retired | output | CNTW | Retired token count |
| cycles | output | CNTW | Elapsed cycle count |

## Verification
Two things can happen on the same edge. A writer can leave execute and clear its bit while a newer writer of the same register either sits in issue or leaves decode and sets the bit. A directed writer-writer-reader sequence provokes this, and the reader must reach execute in cycle 8, not earlier. Random streams drawn over only six registers create these collisions often. A bench model that keeps a pending-writer count per register checks every stage, the stall flag and both counters on every cycle.

// File: rtl/hzd_stall_pipe.sv
module hzd_stall_pipe #(
  parameter int NREG = 32,
  parameter int NSRC = 3,
  parameter int TAGW = 8,
  parameter int CNTW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [TAGW-1:0]           in_tag,
  input  logic                      in_dst_en,
  input  logic [$clog2(NREG)-1:0]   in_dst,
  input  logic [NSRC-1:0]           in_src_en,
  input  logic [NSRC*$clog2(NREG)-1:0] in_src,
  output logic                      fetch_take,
  output logic                      stall,
  output logic                      dec_valid,
  output logic [TAGW-1:0]           dec_tag,
  output logic                      iss_valid,
  output logic [TAGW-1:0]           iss_tag,
  output logic                      exe_valid,
  output logic [TAGW-1:0]           exe_tag,
  output logic [CNTW-1:0]           retired,
  output logic [CNTW-1:0]           cycles
);
  localparam int RW = $clog2(NREG);
  localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};

  logic [NREG-1:0]    busy;
  logic               d_de, i_de, x_de;
  logic [RW-1:0]      d_dst, i_dst, x_dst;
  logic [NSRC-1:0]    d_se;
  logic [NSRC*RW-1:0] d_src;
  logic [NSRC-1:0]    hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = d_se[g] && busy[d_src[g*RW +: RW]];
  end

  assign stall      = dec_valid && (|hit);
  assign fetch_take = in_valid && !stall;

  logic adv, keep;
  logic [NREG-1:0] set_m, clr_m;
  assign adv   = dec_valid && !stall;
  assign set_m = (adv && d_de) ? (ONE << d_dst) : '0;
  assign keep  = (iss_valid && i_de && i_dst == x_dst) || (adv && d_de && d_dst == x_dst);
  assign clr_m = (exe_valid && x_de && !keep) ? (ONE << x_dst) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      dec_valid <= 1'b0;
      dec_tag   <= '0;
      d_de      <= 1'b0;
      d_dst     <= '0;
      d_se      <= '0;
      d_src     <= '0;
      iss_valid <= 1'b0;
      iss_tag   <= '0;
      i_de      <= 1'b0;
      i_dst     <= '0;
      exe_valid <= 1'b0;
      exe_tag   <= '0;
      x_de      <= 1'b0;
      x_dst     <= '0;
      retired   <= '0;
      cycles    <= '0;
    end else begin
      busy <= (busy & ~clr_m) | set_m;
      if (!stall) begin
        dec_valid <= in_valid;
        dec_tag   <= in_tag;
        d_de      <= in_dst_en;
        d_dst     <= in_dst;
        d_se      <= in_src_en;
        d_src     <= in_src;
      end
      iss_valid <= adv;
      iss_tag   <= dec_tag;
      i_de      <= d_de;
      i_dst     <= d_dst;
      exe_valid <= iss_valid;
      exe_tag   <= iss_tag;
      x_de      <= i_de;
      x_dst     <= i_dst;
      retired   <= retired + CNTW'(exe_valid);
      cycles    <= cycles + 1'b1;
    end
  end
endmodule

// File: rtl/hzd_stall_pipe_chk.sv
module hzd_stall_pipe_chk #(
  parameter int NREG = 32,
  parameter int TAGW = 8,
  parameter int CNTW = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_take,
  input logic                    stall,
  input logic [TAGW-1:0]         in_tag,
  input logic                    dec_valid,
  input logic [TAGW-1:0]         dec_tag,
  input logic                    iss_valid,
  input logic [TAGW-1:0]         iss_tag,
  input logic                    exe_valid,
  input logic [TAGW-1:0]         exe_tag,
  input logic [CNTW-1:0]         retired,
  input logic [NREG-1:0]         busy,
  input logic                    i_de,
  input logic [$clog2(NREG)-1:0] i_dst,
  input logic                    x_de,
  input logic [$clog2(NREG)-1:0] x_dst
);
  AST_DECODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |=> dec_valid && dec_tag == $past(in_tag)); // R2
  AST_ISSUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall) |=> iss_valid && iss_tag == $past(dec_tag)); // R3
  AST_EXE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> exe_valid && exe_tag == $past(iss_tag)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> dec_valid && $stable(dec_tag) && !iss_valid); // R5
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && i_de) |-> busy[i_dst]); // R4
  AST_WAW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && x_de && iss_valid && i_de && i_dst == x_dst) |=> busy[$past(x_dst)]); // R8
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |=> retired == $past(retired) + 1'b1); // R9
endmodule

bind hzd_stall_pipe hzd_stall_pipe_chk #(.NREG(NREG), .TAGW(TAGW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_take(fetch_take), .stall(stall), .in_tag(in_tag),
  .dec_valid(dec_valid), .dec_tag(dec_tag), .iss_valid(iss_valid), .iss_tag(iss_tag),
  .exe_valid(exe_valid), .exe_tag(exe_tag), .retired(retired), .busy(busy),
  .i_de(i_de), .i_dst(i_dst), .x_de(x_de), .x_dst(x_dst));

// File: tb/sim_hzd_stall_pipe.sv
`timescale 1ns/100ps
module sim_hzd_stall_pipe;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_dst_en = 1'b0;
  logic [7:0] in_tag = '0;
  logic [4:0] in_dst = '0;
  logic [2:0] in_src_en = '0;
  logic [14:0] in_src = '0;
  logic fetch_take, stall, dec_valid, iss_valid, exe_valid;
  logic [7:0] dec_tag, iss_tag, exe_tag;
  logic [31:0] retired, cycles;

  always #2.5 clk = ~clk;

  hzd_stall_pipe u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_src_en(in_src_en), .in_src(in_src),
    .fetch_take(fetch_take), .stall(stall), .dec_valid(dec_valid), .dec_tag(dec_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .exe_valid(exe_valid), .exe_tag(exe_tag),
    .retired(retired), .cycles(cycles));

  int total = 0, bad = 0, step_n = 0, nstall = 0;
  bit finished = 0, consumed;
  int pend [32];
  int exe_at [256];
  bit md_v, md_de, mi_v, mi_de, mx_v, mx_de;
  logic [7:0] md_tag, mi_tag, mx_tag;
  logic [4:0] md_dst, mi_dst, mx_dst;
  logic [2:0] md_se;
  logic [14:0] md_src;
  int m_ret = 0, m_cyc = 0;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at step %0d", rq, act, exp, step_n);
    end
  endtask

  function automatic bit m_stall();
    bit s = 0;
    for (int g = 0; g < 3; g++)
      if (md_se[g] && pend[md_src[g*5 +: 5]] > 0) s = 1;
    return md_v && s;
  endfunction

  task automatic step();
    bit ms, mt;
    #1;
    ms = m_stall();
    mt = in_valid && !ms;
    chk("R4 stall", int'(stall), int'(ms));
    chk("R5/R2 fetch_take", int'(fetch_take), int'(mt));
    if (ms) nstall++;
    if (mx_v && mx_de) pend[mx_dst]--;
    if (!ms && md_v && md_de) pend[md_dst]++;
    m_ret += int'(mx_v);
    m_cyc++;
    mx_v = mi_v; mx_tag = mi_tag; mx_de = mi_de; mx_dst = mi_dst;
    mi_v = md_v && !ms; mi_tag = md_tag; mi_de = md_de; mi_dst = md_dst;
    if (!ms) begin
      md_v = in_valid; md_tag = in_tag; md_de = in_dst_en; md_dst = in_dst;
      md_se = in_src_en; md_src = in_src;
    end
    consumed = !in_valid || mt;
    step_n++;
    @(negedge clk);
    chk("R2 dec_valid", int'(dec_valid), int'(md_v));
    if (md_v) chk("R5 dec_tag", int'(dec_tag), int'(md_tag));
    chk("R5 iss_valid", int'(iss_valid), int'(mi_v));
    if (mi_v) chk("R3 iss_tag", int'(iss_tag), int'(mi_tag));
    chk("R3 exe_valid", int'(exe_valid), int'(mx_v));
    if (mx_v) chk("R3 exe_tag", int'(exe_tag), int'(mx_tag));
    chk("R9 retired", int'(retired), m_ret);
    chk("R9 cycles", int'(cycles), m_cyc);
    if (exe_valid) exe_at[exe_tag] = step_n;
  endtask

  task automatic put(input bit v, input int tag, input bit de, input int dst,
                     input int se, input int s0, input int s1, input int s2);
    in_valid = v; in_tag = 8'(tag); in_dst_en = de; in_dst = 5'(dst);
    in_src_en = 3'(se); in_src = {5'(s2), 5'(s1), 5'(s0)};
    do step(); while (!consumed);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic int cyc_of(input int tag, input int base);
    return exe_at[tag] - base + 1;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int base, st0;
    void'($urandom(32'h5eed));
    for (int r = 0; r < 32; r++) pend[r] = 0;
    md_v = 0; mi_v = 0; mx_v = 0; md_de = 0; mi_de = 0; mx_de = 0;
    md_tag = 0; mi_tag = 0; mx_tag = 0; md_dst = 0; mi_dst = 0; mx_dst = 0;
    md_se = 0; md_src = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset dec", int'(dec_valid), 0);
    chk("R1 reset iss", int'(iss_valid), 0);
    chk("R1 reset exe", int'(exe_valid), 0);
    chk("R1 reset stall", int'(stall), 0);
    chk("R1 reset retired", int'(retired), 0);
    chk("R1 reset cycles", int'(cycles), 0);
    rst_n = 1'b1;
    idle(2);

    base = step_n; st0 = nstall;
    put(1, 1, 1, 3, 3'b001, 4, 0, 0);
    put(1, 2, 0, 0, 3'b001, 3, 0, 0);
    put(1, 3, 1, 1, 3'b001, 3, 0, 0);
    idle(6);
    chk("R6 writer exe cycle", cyc_of(1, base), 4);
    chk("R6 reader exe cycle", cyc_of(2, base), 7);
    chk("R6 third exe cycle", cyc_of(3, base), 8);
    chk("R6 stall cycles", nstall - st0, 2);

    base = step_n;
    put(1, 4, 1, 5, 0, 0, 0, 0);
    put(1, 5, 1, 5, 0, 0, 0, 0);
    put(1, 6, 0, 0, 3'b001, 5, 0, 0);
    idle(7);
    chk("R8 second writer exe", cyc_of(5, base), 5);
    chk("R8 reader exe cycle", cyc_of(6, base), 8);

    base = step_n;
    put(1, 7, 1, 7, 0, 0, 0, 0);
    put(1, 8, 0, 0, 3'b000, 7, 7, 7);
    idle(5);
    chk("R4 unused slots no stall", cyc_of(8, base), 5);

    base = step_n;
    put(1, 9, 1, 7, 0, 0, 0, 0);
    put(1, 10, 0, 0, 3'b100, 0, 0, 7);
    idle(6);
    chk("R4 slot2 hazard", cyc_of(10, base), 7);

    base = step_n;
    put(1, 11, 0, 9, 0, 0, 0, 0);
    put(1, 12, 0, 0, 3'b001, 9, 0, 0);
    idle(5);
    chk("R7 no-dst no stall", cyc_of(12, base), 5);

    base = step_n;
    for (int k = 0; k < 4; k++) put(1, 13 + k, 1, 20 + k, 3'b011, 10, 11, 0);
    idle(5);
    for (int k = 0; k < 4; k++) chk("R3 back-to-back", cyc_of(13 + k, base), 4 + k);

    for (int n = 0; n < 3000; n++) begin
      put(($urandom % 4) != 0, 100 + (n % 150), $urandom % 2, $urandom % 6,
          $urandom % 8, $urandom % 6, $urandom % 6, $urandom % 6);
    end
    idle(8);
    chk("R9 all retired", int'(retired), m_ret);
    finish_run();
  end
endmodule